// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Through Byte Cache

This block is a small data cache placed between a processor request port and a simpler main-memory port. A byte address is cut into three fields: the low offset bits pick a byte within a 4-byte line, the next index bits pick a set, and the remaining high bits form the tag. Each set holds two lines (ways). Both ways of the selected set are compared against the tag in parallel. A way-select multiplexer steered by the matching way, followed by a byte-select multiplexer steered by the offset, produces the read byte. The default geometry is a 20-bit tag, 1024 sets and a 2-bit byte offset.

Reads that hit are answered without touching memory. A read miss fetches the whole line from memory into one way of the set. An empty way is used first; otherwise the way marked by the set's single least-recently-used bit is used. Every write goes to memory. A write that hits also patches the one addressed byte in the cache. A write that misses leaves the cache untouched.

The processor request is a valid/ready stream. The cache raises `cpu_req_ready` only when idle, so a request is taken on the first edge where both are high. It then holds ready low until the response pulse has been issued. The response is a one-cycle `cpu_rsp_valid` pulse that cannot be back-pressured. The memory request is also valid/ready: the cache holds valid, address, direction and data steady until the memory raises ready. A line fill is returned as a one-cycle `mem_rsp_valid` pulse carrying all four bytes. A pulse that arrives while no fill is outstanding is ignored.

Top module: `cache2w`

## Requirements
- R1: Address fields are offset = addr[1:0], set = addr[IDX_W+1:2] and tag = all higher bits. A line fill is requested with mem_req_write = 0 at the line-aligned address (offset bits zero), and the 4 returned bytes occupy line bits [8*k+7:8*k] for offset k.
- R2: A read whose tag matches a valid way of its set returns the addressed byte with cpu_rsp_valid one cycle after the cycle following acceptance, and issues no memory request.
- R3: A read miss requests the line from memory, stalls with cpu_req_ready low until mem_rsp_valid arrives, and returns the addressed byte of the fetched line on the cycle after it.
- R4: On a read miss, way 0 is filled if it is invalid, else way 1 if it is invalid.
- R5: With both ways valid, a read miss replaces the least-recently-used way. Read hits, write hits and fills each mark the used way as most recently used.
- R6: Every write, hit or miss, is sent to memory (mem_req_write = 1, byte address, byte data). cpu_rsp_valid for that write follows the edge on which memory accepts it.
- R7: A write hit updates only the addressed byte of the hitting line; a later read of it hits and returns the new value.
- R8: A write miss allocates no line; a later read of that address misses and fetches from memory.
- R9: Reset clears every valid bit and every LRU bit; after reset cpu_req_ready is high and cpu_rsp_valid and mem_req_valid are low, and the first read of any address misses.
- R10: cpu_req_ready is low from the cycle after acceptance until the response; mem_req_valid with its address and direction stays stable until mem_req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Cache idle and accepting a request |
| cpu_req_write | input | 1 | 1 = byte write, 0 = byte read |
| cpu_req_addr | input | ADDR_W | Byte address |
| cpu_req_wdata | input | 8 | Write byte |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse |
| cpu_rsp_rdata | output | 8 | Read byte (zero for writes) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = byte write, 0 = line read |
| mem_req_addr | output | ADDR_W | Byte address, or line-aligned address for reads |
| mem_req_wdata | output | 8 | Byte to write |
| mem_rsp_valid | input | 1 | Line fill data valid pulse |
| mem_rsp_line | input | 8 << OFF_W | Fetched line |

## Verification
The bench builds the cache with IDX_W = 2, so there are only four sets. A pool of three tags per set then forces both ways full and LRU victims within a few operations. The memory side inserts periodic ready stalls and a fixed fill latency. This exercises holding a memory request stable and the stalled miss path. The default 1024-set geometry is covered only by RTL elaboration.

// File: rtl/cache2w_pkg.sv
package cache2w_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_MREQ,
    ST_MWAIT
  } cache_st_e;

  localparam int NUM_WAYS = 2;
endpackage

// File: rtl/cache2w_way.sv
module cache2w_way #(
  parameter int TAG_W = 20,
  parameter int IDX_W = 10,
  parameter int OFF_W = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [IDX_W-1:0]         idx,
  input  logic [TAG_W-1:0]         tag,
  input  logic [OFF_W-1:0]         off,
  input  logic                     fill_en,
  input  logic [(8<<OFF_W)-1:0]    fill_line,
  input  logic                     byte_we,
  input  logic [7:0]               byte_data,
  output logic                     vld,
  output logic                     hit,
  output logic [(8<<OFF_W)-1:0]    line
);
  localparam int SETS   = 1 << IDX_W;
  localparam int LINE_W = 8 << OFF_W;

  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] data_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       valid_q <= '0;
    else if (fill_en) valid_q[idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[idx]  <= tag;
      data_q[idx] <= fill_line;
    end else if (byte_we) begin
      data_q[idx][{off, 3'b000} +: 8] <= byte_data;
    end
  end

  assign vld  = valid_q[idx];
  assign hit  = valid_q[idx] && (tag_q[idx] == tag);
  assign line = data_q[idx];

  // R7: a byte write lands only on a line that already matched
  a_r7_patch_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    byte_we |-> hit);
endmodule

// File: rtl/cache2w_lru.sv
module cache2w_lru #(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic             upd,
  input  logic             used_way,
  output logic             victim
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0] lru_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   lru_q <= '0;
    else if (upd) lru_q[idx] <= ~used_way;
  end

  assign victim = lru_q[idx];

  // R5: after a use, the same set points away from the used way
  a_r5_points_away: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (idx != $past(idx)) || (victim != $past(used_way)));
endmodule

// File: rtl/cache2w_ctrl.sv
module cache2w_ctrl
  import cache2w_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cpu_req_valid,
  output logic                     cpu_req_ready,
  input  logic                     cpu_req_write,
  input  logic [ADDR_W-1:0]        cpu_req_addr,
  input  logic [7:0]               cpu_req_wdata,
  output logic                     cpu_rsp_valid,
  output logic [7:0]               cpu_rsp_rdata,
  output logic                     mem_req_valid,
  input  logic                     mem_req_ready,
  output logic                     mem_req_write,
  output logic [ADDR_W-1:0]        mem_req_addr,
  output logic [7:0]               mem_req_wdata,
  input  logic                     mem_rsp_valid,
  input  logic [(8<<OFF_W)-1:0]    mem_rsp_line,
  output logic [IDX_W-1:0]         idx,
  output logic [ADDR_W-IDX_W-OFF_W-1:0] tag,
  output logic [OFF_W-1:0]         off,
  input  logic [NUM_WAYS-1:0]      hit_vec,
  input  logic [NUM_WAYS-1:0]      vld_vec,
  input  logic [(8<<OFF_W)-1:0]    hit_line,
  input  logic                     lru_victim,
  output logic [NUM_WAYS-1:0]      fill_vec,
  output logic [NUM_WAYS-1:0]      bwe_vec,
  output logic [7:0]               byte_data,
  output logic                     lru_upd,
  output logic                     lru_way
);
  localparam int LINE_W = 8 << OFF_W;

  cache_st_e         st_q;
  logic [ADDR_W-1:0] a_q;
  logic              w_q;
  logic [7:0]        d_q;
  logic              rsp_v_q;
  logic [7:0]        rsp_d_q;
  logic              any_hit;
  logic              fill_way;
  logic              fill_now;

  function automatic logic [7:0] pick_byte(input logic [LINE_W-1:0] l,
                                           input logic [OFF_W-1:0] o);
    return l[{o, 3'b000} +: 8];
  endfunction

  assign off = a_q[OFF_W-1:0];
  assign idx = a_q[IDX_W+OFF_W-1:OFF_W];
  assign tag = a_q[ADDR_W-1:IDX_W+OFF_W];

  assign any_hit  = |hit_vec;
  assign fill_way = !vld_vec[0] ? 1'b0 : (!vld_vec[1] ? 1'b1 : lru_victim);
  assign fill_now = (st_q == ST_MWAIT) && mem_rsp_valid;

  always_comb begin
    for (int w = 0; w < NUM_WAYS; w++) begin
      fill_vec[w] = fill_now && (fill_way == w[0]);
      bwe_vec[w]  = (st_q == ST_LOOK) && w_q && hit_vec[w];
    end
  end

  assign byte_data = d_q;
  assign lru_upd   = ((st_q == ST_LOOK) && any_hit) || fill_now;
  assign lru_way   = (st_q == ST_LOOK) ? hit_vec[1] : fill_way;

  assign cpu_req_ready = (st_q == ST_IDLE);
  assign cpu_rsp_valid = rsp_v_q;
  assign cpu_rsp_rdata = rsp_d_q;
  assign mem_req_valid = (st_q == ST_MREQ);
  assign mem_req_write = w_q;
  assign mem_req_addr  = w_q ? a_q : {a_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_req_wdata = d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      a_q     <= '0;
      w_q     <= 1'b0;
      d_q     <= '0;
      rsp_v_q <= 1'b0;
      rsp_d_q <= '0;
    end else begin
      rsp_v_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (cpu_req_valid) begin
          a_q  <= cpu_req_addr;
          w_q  <= cpu_req_write;
          d_q  <= cpu_req_wdata;
          st_q <= ST_LOOK;
        end
        ST_LOOK: begin
          if (!w_q && any_hit) begin
            rsp_v_q <= 1'b1;
            rsp_d_q <= pick_byte(hit_line, off);
            st_q    <= ST_IDLE;
          end else begin
            st_q <= ST_MREQ;
          end
        end
        ST_MREQ: if (mem_req_ready) begin
          if (w_q) begin
            rsp_v_q <= 1'b1;
            rsp_d_q <= '0;
            st_q    <= ST_IDLE;
          end else begin
            st_q <= ST_MWAIT;
          end
        end
        ST_MWAIT: if (mem_rsp_valid) begin
          rsp_v_q <= 1'b1;
          rsp_d_q <= pick_byte(mem_rsp_line, off);
          st_q    <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R10: busy after acceptance
  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_valid && cpu_req_ready |=> !cpu_req_ready);
  // R10: memory request held until taken
  a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));
  // R6: write completes right after memory takes it
  a_r6_write_done: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready && mem_req_write |=> cpu_rsp_valid);
  // R2: no response pulse while a request is still being taken
  a_r2_no_early_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req_valid && cpu_req_ready |=> !cpu_rsp_valid);
endmodule

// File: rtl/cache2w.sv
module cache2w
  import cache2w_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cpu_req_valid,
  output logic                  cpu_req_ready,
  input  logic                  cpu_req_write,
  input  logic [ADDR_W-1:0]     cpu_req_addr,
  input  logic [7:0]            cpu_req_wdata,
  output logic                  cpu_rsp_valid,
  output logic [7:0]            cpu_rsp_rdata,
  output logic                  mem_req_valid,
  input  logic                  mem_req_ready,
  output logic                  mem_req_write,
  output logic [ADDR_W-1:0]     mem_req_addr,
  output logic [7:0]            mem_req_wdata,
  input  logic                  mem_rsp_valid,
  input  logic [(8<<OFF_W)-1:0] mem_rsp_line
);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W = 8 << OFF_W;

  logic [IDX_W-1:0]    idx;
  logic [TAG_W-1:0]    tag;
  logic [OFF_W-1:0]    off;
  logic [NUM_WAYS-1:0] hit_vec, vld_vec, fill_vec, bwe_vec;
  logic [LINE_W-1:0]   way_line [NUM_WAYS];
  logic [LINE_W-1:0]   hit_line;
  logic [7:0]          byte_data;
  logic                lru_upd, lru_way, lru_victim;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    cache2w_way #(.TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_way (
      .clk       (clk),
      .rst_n     (rst_n),
      .idx       (idx),
      .tag       (tag),
      .off       (off),
      .fill_en   (fill_vec[w]),
      .fill_line (mem_rsp_line),
      .byte_we   (bwe_vec[w]),
      .byte_data (byte_data),
      .vld       (vld_vec[w]),
      .hit       (hit_vec[w]),
      .line      (way_line[w])
    );
  end

  assign hit_line = hit_vec[1] ? way_line[1] : way_line[0];

  cache2w_lru #(.IDX_W(IDX_W)) u_lru (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx      (idx),
    .upd      (lru_upd),
    .used_way (lru_way),
    .victim   (lru_victim)
  );

  cache2w_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_ready (cpu_req_ready),
    .cpu_req_write (cpu_req_write),
    .cpu_req_addr  (cpu_req_addr),
    .cpu_req_wdata (cpu_req_wdata),
    .cpu_rsp_valid (cpu_rsp_valid),
    .cpu_rsp_rdata (cpu_rsp_rdata),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_line  (mem_rsp_line),
    .idx           (idx),
    .tag           (tag),
    .off           (off),
    .hit_vec       (hit_vec),
    .vld_vec       (vld_vec),
    .hit_line      (hit_line),
    .lru_victim    (lru_victim),
    .fill_vec      (fill_vec),
    .bwe_vec       (bwe_vec),
    .byte_data     (byte_data),
    .lru_upd       (lru_upd),
    .lru_way       (lru_way)
  );

  // R2: a tag can live in only one way of a set
  a_r2_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(hit_vec) <= 1);
  // R4: an empty way 0 is always the fill target
  a_r4_empty_first: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_vec != '0) && !vld_vec[0] |-> fill_vec[0]);
  // R8: a write never allocates a line
  a_r8_no_write_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_vec != '0) |-> !mem_req_write);
endmodule

// File: tb/cache2w_bench.sv
module cache2w_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = 2;
  localparam int OFF_W  = 2;
  localparam int SETS   = 1 << IDX_W;
  localparam int NBYTES = 1 << OFF_W;
  localparam int LAT    = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
  logic [ADDR_W-1:0] cpu_req_addr = '0;
  logic [7:0] cpu_req_wdata = '0;
  logic cpu_req_ready, cpu_rsp_valid;
  logic [7:0] cpu_rsp_rdata;
  logic mem_req_valid, mem_req_write;
  logic [ADDR_W-1:0] mem_req_addr;
  logic [7:0] mem_req_wdata;
  logic mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [(8<<OFF_W)-1:0] mem_rsp_line = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cache2w #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_cache2w (.*);

  int checks = 0, errors = 0, mem_reads = 0, cyc = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dflt(input logic [31:0] a);
    return a[7:0] ^ a[11:4] ^ 8'hA5;
  endfunction

  // memory contents seen by the memory port, and the model's own copy
  logic [7:0] mem_act [logic [31:0]];
  logic [7:0] mem_exp [logic [31:0]];

  function automatic logic [7:0] rd_act(input logic [31:0] a);
    return mem_act.exists(a) ? mem_act[a] : dflt(a);
  endfunction
  function automatic logic [7:0] rd_exp(input logic [31:0] a);
    return mem_exp.exists(a) ? mem_exp[a] : dflt(a);
  endfunction

  // memory responder
  bit pend = 0;
  int lat_cnt = 0;
  logic [31:0] pend_addr = '0;

  always @(posedge clk) begin
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (mem_req_write) mem_act[mem_req_addr] = mem_req_wdata;
      else begin
        chk(mem_req_addr[OFF_W-1:0] == '0, "R1 fill address aligned",
            mem_req_addr, {mem_req_addr[31:OFF_W], {OFF_W{1'b0}}});
        pend = 1; pend_addr = mem_req_addr; lat_cnt = LAT; mem_reads++;
      end
    end
  end

  always @(negedge clk) begin
    cyc++;
    mem_req_ready = rst_n && ((cyc % 3) != 1);
    mem_rsp_valid = 1'b0;
    if (pend) begin
      if (lat_cnt == 0) begin
        for (int b = 0; b < NBYTES; b++) mem_rsp_line[8*b +: 8] = rd_act(pend_addr + b);
        mem_rsp_valid = 1'b1;
        pend = 0;
      end else lat_cnt--;
    end
  end

  // reference model
  bit          mv   [SETS][2];
  int unsigned mt   [SETS][2];
  logic [7:0]  md   [SETS][2][NBYTES];
  bit          mlru [SETS];

  task automatic do_op(input bit w, input logic [31:0] a, input logic [7:0] d, input string tagr);
    int s, o, hw, n, rd0, vic;
    int unsigned t;
    logic [7:0] exp;
    s = int'(a[IDX_W+OFF_W-1:OFF_W]);
    o = int'(a[OFF_W-1:0]);
    t = a >> (IDX_W + OFF_W);
    hw = -1;
    for (int k = 0; k < 2; k++) if (mv[s][k] && mt[s][k] == t) hw = k;
    rd0 = mem_reads;
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = w; cpu_req_addr = a; cpu_req_wdata = d;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    chk(!cpu_req_ready, "R10 ready low while busy", cpu_req_ready, 0);
    n = 0;
    do begin @(negedge clk); n++; end while (!cpu_rsp_valid && n < 60);
    chk(cpu_rsp_valid, {tagr, " response arrives"}, cpu_rsp_valid, 1);
    if (w) begin
      mem_exp[a] = d;
      chk(rd_act(a) == d, {tagr, " R6 memory written"}, rd_act(a), d);
      chk(mem_reads == rd0, {tagr, " R8 no fill on write"}, mem_reads, rd0);
      if (hw >= 0) begin md[s][hw][o] = d; mlru[s] = (hw == 0); end
    end else if (hw >= 0) begin
      exp = md[s][hw][o];
      chk(cpu_rsp_rdata == exp, {tagr, " R2 hit data"}, cpu_rsp_rdata, exp);
      chk(n == 1, {tagr, " R2 hit latency"}, n, 1);
      chk(mem_reads == rd0, {tagr, " R2 no memory on hit"}, mem_reads, rd0);
      mlru[s] = (hw == 0);
    end else begin
      vic = !mv[s][0] ? 0 : (!mv[s][1] ? 1 : int'(mlru[s]));
      mv[s][vic] = 1; mt[s][vic] = t;
      for (int b = 0; b < NBYTES; b++) md[s][vic][b] = rd_exp({a[31:OFF_W], {OFF_W{1'b0}}} + b);
      mlru[s] = (vic == 0);
      exp = md[s][vic][o];
      chk(cpu_rsp_rdata == exp, {tagr, " R3 miss data"}, cpu_rsp_rdata, exp);
      chk(mem_reads == rd0 + 1, {tagr, " R3 one fill"}, mem_reads, rd0 + 1);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    finish_run();
  end

  initial begin
    for (int s = 0; s < SETS; s++) begin
      mlru[s] = 0;
      for (int k = 0; k < 2; k++) mv[s][k] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: idle state after reset
    chk(cpu_req_ready == 1'b1, "R9 ready after reset", cpu_req_ready, 1);
    chk(cpu_rsp_valid == 1'b0, "R9 no response after reset", cpu_rsp_valid, 0);
    chk(mem_req_valid == 1'b0, "R9 no memory request after reset", mem_req_valid, 0);

    do_op(0, 32'h100, 8'h0, "R9 first read misses");
    do_op(0, 32'h101, 8'h0, "R2 hit same line");
    do_op(0, 32'h203, 8'h0, "R4 second way empty");
    do_op(0, 32'h102, 8'h0, "R5 hit refresh way0");
    do_op(0, 32'h300, 8'h0, "R5 evict LRU way1");
    do_op(0, 32'h103, 8'h0, "R5 way0 kept");
    do_op(0, 32'h201, 8'h0, "R5 evicted line misses");
    do_op(1, 32'h101, 8'h3C, "R7 write hit");
    do_op(0, 32'h101, 8'h0, "R7 readback new byte");
    do_op(0, 32'h100, 8'h0, "R7 neighbour byte intact");
    do_op(1, 32'h504, 8'hC3, "R8 write miss");
    do_op(0, 32'h504, 8'h0, "R8 read after write miss");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] a;
      a = ((($urandom % 3) + 1) << (IDX_W + OFF_W)) | (($urandom % SETS) << OFF_W) | ($urandom % NBYTES);
      if (($urandom % 3) == 0) do_op(1, a, 8'($urandom), "R6 random write");
      else do_op(0, a, 8'h0, "R5 random read");
    end
    finish_run();
  end
endmodule